// File: doc/BRIEF.md
# Codec Command Slot Controller

This block carries software accesses to the registers of an external audio codec. Software first loads a data slot and then a command slot. Loading the command slot starts one codec register access. One bit of the command word selects between a register write and a register read. The block drives a small codec register port with an address, write data, one-cycle write and read strobes, read data, and a done pulse.

When a read finishes, the block places the result in two receive slots, laid out the way a serial frame would carry it. It then raises a pair of valid flags. A flag word reports whether each transmit slot is empty, whether a read is still waiting, and whether the receive slots hold fresh data. The frame serialiser and the analog codec sit outside this block.

Software reaches five slots through an index: 0 command, 1 data, 2 receive A, 3 receive B, 4 flags.

Top module: `cmdslot_ctrl`

## Requirements
- R1: After synchronous reset, the flag word reads 0x07: command-empty (bit 0), data-empty (bit 1) and both-empty (bit 2) are set, and all other bits are clear. Both receive slots read 0, and neither codec strobe is active.
- R2: A write to the command slot (index 0) with bit 19 clear, while no access is pending, starts a codec register write. `cdc_wr` is high for exactly one cycle, in the cycle after the slot write. During that cycle `cdc_addr` equals command bits 18:12 and `cdc_wdata` equals data-slot bits 19:4.
- R3: A command-slot write with bit 19 set starts a codec register read. `cdc_rd` is high for one cycle, in the cycle after the slot write, with the same address field, and `cdc_wr` stays low.
- R4: A write to the command slot clears flag bit 0. A write to the data slot (index 1) clears flag bit 1. Flag bit 2 is the AND of bits 0 and 1.
- R5: From the cycle a read is issued until its `cdc_done`, both receive-busy flags (bits 3 and 4) are set.
- R6: At the `cdc_done` of a read, four things happen. Receive slot A (index 2) takes the command word with bit 19 cleared. Receive slot B (index 3) takes `cdc_rdata` shifted left by 4. Both busy flags clear. Both valid flags (bits 5 and 6) set.
- R7: A command-slot write made while an access is pending is ignored: the stored command word is unchanged and no strobe is issued.
- R8: At `cdc_done`, flag bit 0 sets again. A completed write also sets flag bit 1 again, unless the data slot is written in that same cycle.
- R9: Reading receive slot A clears valid bit 5, and reading slot B clears bit 6. If a read completes in the same cycle as such a slot read, the old slot value is returned and the valid flag stays set.
- R10: A `cdc_done` pulse while no access is pending changes neither the receive slots nor the flags.
- R11: `sw_rdata` shows the indexed slot in the cycle after `sw_rd`. Indices 5 to 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Software slot write strobe |
| sw_rd | input | 1 | Software slot read strobe |
| sw_idx | input | 3 | Slot index |
| sw_wdata | input | 20 | Slot write value |
| sw_rdata | output | 20 | Registered slot read value |
| cdc_addr | output | 7 | Codec register address |
| cdc_wdata | output | 16 | Codec register write data |
| cdc_wr | output | 1 | Codec write strobe, one cycle |
| cdc_rd | output | 1 | Codec read strobe, one cycle |
| cdc_rdata | input | 16 | Codec read data, valid with cdc_done |
| cdc_done | input | 1 | Codec access completion pulse |

## Verification
Two pairs of actions can land in the same cycle. The first is a read completion arriving together with a software read of receive slot A. The bench raises `cdc_done` in the exact cycle that `sw_rd` targets that slot. It expects the old slot value back and the valid flag still set afterwards. The second is a write completion coinciding with a new data-slot write, where the bench expects the data-empty flag to stay clear.

// File: rtl/cmdslot_pkg.sv
package cmdslot_pkg;
  localparam int IDX_W = 3;
  typedef enum logic [IDX_W-1:0] {
    IDX_CMD = 3'd0,
    IDX_DAT = 3'd1,
    IDX_RXA = 3'd2,
    IDX_RXB = 3'd3,
    IDX_FLG = 3'd4
  } slot_idx_e;

  localparam int FL_CMD_EMPTY  = 0;
  localparam int FL_DAT_EMPTY  = 1;
  localparam int FL_BOTH_EMPTY = 2;
  localparam int FL_BUSY_A     = 3;
  localparam int FL_BUSY_B     = 4;
  localparam int FL_VALID_A    = 5;
  localparam int FL_VALID_B    = 6;
  localparam int FL_W          = 7;
  localparam int RX_LANES      = 2;
endpackage

// File: rtl/cmdslot_seq.sv
module cmdslot_seq #(
  parameter int SLOT_W  = 20,
  parameter int CADDR_W = 7,
  parameter int CDATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [SLOT_W-1:0]  go_slot,
  input  logic [SLOT_W-1:0]  dat_slot,
  input  logic               cdc_done,
  output logic [CADDR_W-1:0] cdc_addr,
  output logic [CDATA_W-1:0] cdc_wdata,
  output logic               cdc_wr,
  output logic               cdc_rd,
  output logic               pend,
  output logic               pend_rd,
  output logic               fin,
  output logic               fin_rd
);
  localparam int RW_BIT = SLOT_W - 1;

  // completion is only meaningful while an access is outstanding
  assign fin    = pend && cdc_done;
  assign fin_rd = fin && pend_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_rd   <= 1'b0;
      cdc_wr    <= 1'b0;
      cdc_rd    <= 1'b0;
      cdc_addr  <= '0;
      cdc_wdata <= '0;
    end else begin
      cdc_wr <= 1'b0;
      cdc_rd <= 1'b0;
      if (go) begin
        pend      <= 1'b1;
        pend_rd   <= go_slot[RW_BIT];
        cdc_wr    <= !go_slot[RW_BIT];
        cdc_rd    <= go_slot[RW_BIT];
        cdc_addr  <= go_slot[RW_BIT-1 -: CADDR_W];
        cdc_wdata <= dat_slot[SLOT_W-1 -: CDATA_W];
      end else if (fin) begin
        pend    <= 1'b0;
        pend_rd <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmdslot_rx.sv
module cmdslot_rx
  import cmdslot_pkg::*;
#(
  parameter int SLOT_W  = 20,
  parameter int CDATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_rd,
  input  logic                fin_rd,
  input  logic [SLOT_W-1:0]   cmd_slot,
  input  logic [CDATA_W-1:0]  cdc_rdata,
  input  logic [RX_LANES-1:0] take,
  output logic [SLOT_W-1:0]   rx_a,
  output logic [SLOT_W-1:0]   rx_b,
  output logic [RX_LANES-1:0] busy,
  output logic [RX_LANES-1:0] valid
);
  localparam int SHIFT = SLOT_W - CDATA_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_a <= '0;
      rx_b <= '0;
      busy <= '0;
    end else if (fin_rd) begin
      rx_a <= {1'b0, cmd_slot[SLOT_W-2:0]};
      rx_b <= {cdc_rdata, {SHIFT{1'b0}}};
      busy <= '0;
    end else if (start_rd) begin
      busy <= '1;
    end
  end

  // completion outranks a software read of the same lane
  for (genvar i = 0; i < RX_LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)          valid[i] <= 1'b0;
      else if (fin_rd)  valid[i] <= 1'b1;
      else if (take[i]) valid[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdslot_ctrl.sv
module cmdslot_ctrl
  import cmdslot_pkg::*;
#(
  parameter int SLOT_W  = 20,
  parameter int CADDR_W = 7,
  parameter int CDATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_wr,
  input  logic               sw_rd,
  input  logic [IDX_W-1:0]   sw_idx,
  input  logic [SLOT_W-1:0]  sw_wdata,
  output logic [SLOT_W-1:0]  sw_rdata,
  output logic [CADDR_W-1:0] cdc_addr,
  output logic [CDATA_W-1:0] cdc_wdata,
  output logic               cdc_wr,
  output logic               cdc_rd,
  input  logic [CDATA_W-1:0] cdc_rdata,
  input  logic               cdc_done
);
  localparam int RW_BIT = SLOT_W - 1;

  logic [SLOT_W-1:0]   cmd_q, dat_q, rx_a, rx_b;
  logic                cmd_empty, dat_empty;
  logic                pend, pend_rd, fin, fin_rd;
  logic [RX_LANES-1:0] rx_busy, rx_valid, take;
  logic [FL_W-1:0]     flag_v;
  logic                wr_cmd, wr_dat, go;

  assign wr_cmd = sw_wr && (sw_idx == IDX_CMD);
  assign wr_dat = sw_wr && (sw_idx == IDX_DAT);
  assign go     = wr_cmd && !pend;
  assign take   = {sw_rd && (sw_idx == IDX_RXB), sw_rd && (sw_idx == IDX_RXA)};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      dat_q     <= '0;
      cmd_empty <= 1'b1;
      dat_empty <= 1'b1;
    end else begin
      if (go)     cmd_q <= sw_wdata;
      if (wr_dat) dat_q <= sw_wdata;
      if (go)       cmd_empty <= 1'b0;
      else if (fin) cmd_empty <= 1'b1;
      if (wr_dat)                  dat_empty <= 1'b0;
      else if (fin && !pend_rd)    dat_empty <= 1'b1;
    end
  end

  cmdslot_seq #(.SLOT_W(SLOT_W), .CADDR_W(CADDR_W), .CDATA_W(CDATA_W)) u_seq (
    .clk(clk), .rst(rst), .go(go), .go_slot(sw_wdata), .dat_slot(dat_q),
    .cdc_done(cdc_done), .cdc_addr(cdc_addr), .cdc_wdata(cdc_wdata),
    .cdc_wr(cdc_wr), .cdc_rd(cdc_rd), .pend(pend), .pend_rd(pend_rd),
    .fin(fin), .fin_rd(fin_rd)
  );

  cmdslot_rx #(.SLOT_W(SLOT_W), .CDATA_W(CDATA_W)) u_rx (
    .clk(clk), .rst(rst), .start_rd(go && sw_wdata[RW_BIT]), .fin_rd(fin_rd),
    .cmd_slot(cmd_q), .cdc_rdata(cdc_rdata), .take(take),
    .rx_a(rx_a), .rx_b(rx_b), .busy(rx_busy), .valid(rx_valid)
  );

  always_comb begin
    flag_v                = '0;
    flag_v[FL_CMD_EMPTY]  = cmd_empty;
    flag_v[FL_DAT_EMPTY]  = dat_empty;
    flag_v[FL_BOTH_EMPTY] = cmd_empty && dat_empty;
    flag_v[FL_BUSY_A]     = rx_busy[0];
    flag_v[FL_BUSY_B]     = rx_busy[1];
    flag_v[FL_VALID_A]    = rx_valid[0];
    flag_v[FL_VALID_B]    = rx_valid[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_rdata <= '0;
    end else if (sw_rd) begin
      case (sw_idx)
        IDX_CMD: sw_rdata <= cmd_q;
        IDX_DAT: sw_rdata <= dat_q;
        IDX_RXA: sw_rdata <= rx_a;
        IDX_RXB: sw_rdata <= rx_b;
        IDX_FLG: sw_rdata <= SLOT_W'(flag_v);
        default: sw_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cmdslot_chk.sv
module cmdslot_chk #(
  parameter int SLOT_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              cdc_wr,
  input logic              cdc_rd,
  input logic              cdc_done,
  input logic              pend,
  input logic [1:0]        rx_busy,
  input logic [1:0]        rx_valid,
  input logic [SLOT_W-1:0] rx_a
);
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(cdc_wr && cdc_rd));
  assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cdc_wr |=> !cdc_wr);
  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    cdc_rd |=> !cdc_rd);
  assert_busy_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    cdc_rd |-> (rx_busy == 2'b11));
  assert_read_done_R6: assert property (@(posedge clk) disable iff (rst)
    ((rx_busy != 2'b00) && cdc_done) |=> ((rx_valid == 2'b11) && (rx_busy == 2'b00)));
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    pend |=> !(cdc_wr || cdc_rd));
  assert_idle_done_R10: assert property (@(posedge clk) disable iff (rst)
    !pend |=> $stable(rx_a));
endmodule

bind cmdslot_ctrl cmdslot_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .cdc_wr(cdc_wr), .cdc_rd(cdc_rd), .cdc_done(cdc_done),
  .pend(pend), .rx_busy(rx_busy), .rx_valid(rx_valid), .rx_a(rx_a)
);

// File: tb/sim_cmdslot_ctrl.sv
`timescale 1ns/1ps
module sim_cmdslot_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_wr = 1'b0, sw_rd = 1'b0;
  logic [2:0]  sw_idx = '0;
  logic [19:0] sw_wdata = '0;
  logic [19:0] sw_rdata;
  logic [6:0]  cdc_addr;
  logic [15:0] cdc_wdata;
  logic        cdc_wr, cdc_rd;
  logic [15:0] cdc_rdata;
  logic        cdc_done;

  logic        auto = 1'b0;
  logic        auto_done = 1'b0, man_done = 1'b0;
  logic [15:0] auto_rdata = '0, man_rdata = '0;
  logic [15:0] cmem [128];
  logic [15:0] shadow [128];
  int          cnt = 0, lat = 1;
  logic [6:0]  cur_a = '0;
  int          n_tests = 0, n_fail = 0;

  assign cdc_done  = auto_done | man_done;
  assign cdc_rdata = auto ? auto_rdata : man_rdata;

  always #2 clk = ~clk;

  cmdslot_ctrl u0 (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_rd(sw_rd), .sw_idx(sw_idx),
    .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .cdc_addr(cdc_addr),
    .cdc_wdata(cdc_wdata), .cdc_wr(cdc_wr), .cdc_rd(cdc_rd),
    .cdc_rdata(cdc_rdata), .cdc_done(cdc_done)
  );

  function automatic logic [15:0] init_val(int i);
    return 16'(i * 16'h0101) ^ 16'h5A5A;
  endfunction

  // flag word layout from R1/R4/R5/R6
  function automatic logic [19:0] exp_flags(bit ce, bit de, bit busy, bit va, bit vb);
    return {13'd0, vb, va, busy, busy, ce & de, de, ce};
  endfunction

  // codec model, active only in auto mode
  always @(negedge clk) begin
    if (auto) begin
      if (cnt == 1) begin
        auto_done  = 1'b1;
        auto_rdata = cmem[cur_a];
        cnt = 0;
      end else begin
        auto_done = 1'b0;
        if (cnt > 1) cnt--;
      end
      if (cdc_wr) begin cmem[cdc_addr] = cdc_wdata; cur_a = cdc_addr; cnt = lat; end
      if (cdc_rd) begin cur_a = cdc_addr; cnt = lat; end
    end else begin
      auto_done = 1'b0;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sw_write(logic [2:0] idx, logic [19:0] d);
    @(negedge clk);
    sw_wr = 1'b1; sw_idx = idx; sw_wdata = d;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic sw_read(logic [2:0] idx, output logic [19:0] v);
    @(negedge clk);
    sw_rd = 1'b1; sw_idx = idx;
    @(negedge clk);
    sw_rd = 1'b0;
    v = sw_rdata;
  endtask

  task automatic man_finish(logic [15:0] rd);
    @(negedge clk);
    man_done = 1'b1; man_rdata = rd;
    @(negedge clk);
    man_done = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [19:0] v;
    for (int i = 0; i < 128; i++) begin
      cmem[i] = init_val(i);
      shadow[i] = init_val(i);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 strobes", {30'd0, cdc_wr, cdc_rd}, 32'd0);
    sw_read(3'd4, v); chk("R1 flags", v, 20'h07);
    sw_read(3'd2, v); chk("R1 rxa", v, 0);
    sw_read(3'd3, v); chk("R1 rxb", v, 0);

    // R2 / R4 directed write
    sw_write(3'd1, 20'hABCDE);
    sw_read(3'd4, v); chk("R4 data write clears bit1", v, exp_flags(1, 0, 0, 0, 0));
    sw_write(3'd0, {1'b0, 7'h15, 12'h000});
    chk("R2 wr strobe", cdc_wr, 1); chk("R2 no rd strobe", cdc_rd, 0);
    chk("R2 addr", cdc_addr, 7'h15); chk("R2 wdata", cdc_wdata, 16'hABCD);
    @(negedge clk); chk("R2 one-cycle pulse", cdc_wr, 0);
    sw_read(3'd4, v); chk("R4 cmd write clears bit0", v, exp_flags(0, 0, 0, 0, 0));
    man_finish(16'h0);
    sw_read(3'd4, v); chk("R8 write completion", v, exp_flags(1, 1, 0, 0, 0));

    // R3 / R5 / R7 directed read
    sw_write(3'd0, {1'b1, 7'h2A, 12'h5A5});
    chk("R3 rd strobe", cdc_rd, 1); chk("R3 no wr strobe", cdc_wr, 0);
    chk("R3 addr", cdc_addr, 7'h2A);
    sw_read(3'd4, v); chk("R5 busy while pending", v, exp_flags(0, 1, 1, 0, 0));
    sw_write(3'd0, 20'h01000);
    chk("R7 no strobe while pending", {30'd0, cdc_wr, cdc_rd}, 0);
    sw_read(3'd0, v); chk("R7 cmd slot kept", v, {1'b1, 7'h2A, 12'h5A5});
    man_finish(16'hBEEF);
    sw_read(3'd4, v); chk("R6 flags at completion", v, exp_flags(1, 1, 0, 1, 1));
    sw_read(3'd2, v); chk("R6 rxa", v, {1'b0, 7'h2A, 12'h5A5});
    sw_read(3'd4, v); chk("R9 rxa read clears bit5", v, exp_flags(1, 1, 0, 0, 1));
    sw_read(3'd3, v); chk("R6 rxb", v, 20'hBEEF0);
    sw_read(3'd4, v); chk("R9 rxb read clears bit6", v, exp_flags(1, 1, 0, 0, 0));

    // R10 done while idle
    man_finish(16'h1234);
    sw_read(3'd2, v); chk("R10 rxa unchanged", v, {1'b0, 7'h2A, 12'h5A5});
    sw_read(3'd3, v); chk("R10 rxb unchanged", v, 20'hBEEF0);
    sw_read(3'd4, v); chk("R10 flags unchanged", v, exp_flags(1, 1, 0, 0, 0));

    // R9 completion in the same cycle as a receive-slot read
    sw_write(3'd0, {1'b1, 7'h11, 12'h001});
    @(negedge clk);
    sw_rd = 1'b1; sw_idx = 3'd2; man_done = 1'b1; man_rdata = 16'h0F0F;
    @(negedge clk);
    sw_rd = 1'b0; man_done = 1'b0;
    chk("R9 old value returned", sw_rdata, {1'b0, 7'h2A, 12'h5A5});
    sw_read(3'd4, v); chk("R9 valid kept on overlap", v, exp_flags(1, 1, 0, 1, 1));
    sw_read(3'd2, v); chk("R6 rxa new", v, 20'h11001);
    sw_read(3'd3, v); chk("R6 rxb new", v, 20'h0F0F0);

    // R8 data write in the cycle a write completes
    sw_write(3'd1, 20'h12340);
    sw_write(3'd0, {1'b0, 7'h03, 12'h000});
    @(negedge clk);
    sw_wr = 1'b1; sw_idx = 3'd1; sw_wdata = 20'h55550; man_done = 1'b1;
    @(negedge clk);
    sw_wr = 1'b0; man_done = 1'b0;
    sw_read(3'd4, v); chk("R8 data write wins", v, exp_flags(1, 0, 0, 0, 0));
    sw_write(3'd0, {1'b0, 7'h04, 12'h000});
    chk("R8 new data used", cdc_wdata, 16'h5555);
    man_finish(16'h0);

    // R11 unused indices
    sw_write(3'd6, 20'hFFFFF);
    sw_read(3'd6, v); chk("R11 idx6 reads 0", v, 0);
    sw_read(3'd5, v); chk("R11 idx5 reads 0", v, 0);
    sw_read(3'd7, v); chk("R11 idx7 reads 0", v, 0);
    sw_read(3'd0, v); chk("R11 cmd untouched", v, 20'h04000);
    sw_read(3'd1, v); chk("R11 data untouched", v, 20'h55550);
    sw_read(3'd4, v); chk("R11 flags untouched", v, exp_flags(1, 1, 0, 0, 0));

    // random transactions
    auto = 1'b1;
    void'($urandom(32'd7));
    for (int it = 0; it < 40; it++) begin
      bit          op;
      logic [6:0]  a;
      logic [15:0] d;
      logic [19:0] cmd;
      op  = 1'($urandom % 2);
      a   = 7'($urandom % 128);
      d   = 16'($urandom);
      lat = 1 + int'($urandom % 4);
      cmd = {op, a, 12'($urandom)};
      sw_write(3'd1, {d, 4'($urandom)});
      sw_write(3'd0, cmd);
      if (op) chk("R3 random rd strobe", {30'd0, cdc_wr, cdc_rd}, 32'd1);
      else    chk("R2 random wr strobe", {30'd0, cdc_wr, cdc_rd}, 32'd2);
      chk("R2 random addr", cdc_addr, a);
      if (!op) begin
        chk("R2 random wdata", cdc_wdata, d);
        shadow[a] = d;
      end
      if (lat >= 3) begin
        sw_write(3'd0, {~op, a, 12'h0});
        chk("R7 random ignored", {30'd0, cdc_wr, cdc_rd}, 0);
      end
      repeat (6) @(negedge clk);
      if (op) begin
        sw_read(3'd4, v); chk("R6 random flags", v, exp_flags(1, 0, 0, 1, 1));
        sw_read(3'd2, v); chk("R6 random rxa", v, {1'b0, cmd[18:0]});
        sw_read(3'd3, v); chk("R6 random rxb", v, {shadow[a], 4'h0});
      end else begin
        sw_read(3'd4, v); chk("R8 random flags", v, exp_flags(1, 1, 0, 0, 0));
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule